// File: doc/BRIEF.md
# Shared-Register Interrupt Combiner

This block gathers a small, parameterised group of peripheral interrupt sources onto one level-sensitive request line for a parent interrupt controller. Software sees one 32-bit register. The low half holds one enable bit per source. The high half holds one sticky pending bit per source, placed exactly sixteen positions above that source's enable. A source that is seen high on a clock edge marks its pending bit. The bit then stays set until software writes a one to it. The combined request is raised while any pending source is also enabled.

Pending bits clear when a one is written to them and keep their value when a zero is written. Software that changes enables with a read-modify-write must therefore put zeros in the pending half. A service routine clears pending bits one at a time, and each clear leaves the other pending bits untouched. The number of sources and the position of the first source are parameters. The required configurations are seven sources from bit 0, six sources from bit 0, and two sources from bit 4. In the last case the enables are bits 5:4 and the pending bits are 21:20.

Top module: `irq_combiner`

## Requirements
- R1: Source i (0 ≤ i < NUM_SRC) has its enable at register bit SRC_BASE+i and its pending bit at SRC_BASE+i+16. A read returns both fields at those positions.
- R2: An enable bit is a plain read/write bit. A write with the strobe of its byte lane set (lane = bit/8) loads it from the write data in the same clock.
- R3: A pending bit becomes 1 on any clock edge at which its source input is high, whatever the enable. It then stays 1 until it is cleared.
- R4: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. Clearing one pending bit leaves every other pending bit as it was.
- R5: If a source is high on the same edge at which its pending bit is written with 1, the bit stays 1.
- R6: irq_out is registered. It goes high one clock after an enabled pending bit exists. It goes low one clock after the last enabled pending bit is cleared or masked.
- R7: A pending source whose enable is 0 does not drive irq_out, and its pending bit stays set while it is masked.
- R8: Register bits outside the configured enable range and pending range read as 0, and writes to them have no effect.
- R9: While rst_n is low at a clock edge, all enable and pending bits clear and irq_out goes low.
- R10: A write whose byte strobe for a lane is low changes no enable or pending bit in that lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write request for this cycle |
| reg_be | input | 4 | Byte strobes; bit k covers data bits 8k+7:8k |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register contents |
| src_in | input | NUM_SRC | Raw interrupt sources, sampled on every clock edge |
| irq_out | output | 1 | Combined level interrupt to the parent controller |

## Verification
The bench drives a source high on the same edge as a write that clears it. A design where the clear wins would lose that interrupt. It writes an enable change with zeros in the pending half and clears pending bits one at a time. A design that cleared the whole field, or cleared on a written zero, would drop interrupts that are still waiting. It also writes with the strobe of a single lane held low, masks a pending source, and checks the exact cycle at which irq_out falls. A design with the wrong lane decode, a combinational output or masking that cleared the pending bit would fail those checks. A second instance with the first source at bit 4 shows whether the bit placement follows the base parameter or is fixed at zero.

// File: rtl/irqc_pkg.sv
// Package: shared layout constants for the interrupt combiner.
// Assumes a 32-bit register split into two 16-bit halves.
package irqc_pkg;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned HALF_W   = 16;
    localparam int unsigned LANE_W   = 8;
    localparam int unsigned N_LANES  = REG_W / LANE_W;
endpackage

// File: rtl/irqc_src_slice.sv
// irqc_src_slice: storage for one source, an enable flop and a sticky pending flop.
// Assumes the parent has already combined the write request with the byte strobe
// of the lane that holds each bit.
module irqc_src_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_d,
    input  logic pend_wr,
    input  logic pend_d,
    input  logic src,
    output logic en_q,
    output logic pend_q
);
    // Enable flop: plain read/write bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (en_wr) en_q <= en_d;
    end

    // Pending flop: set by the source, cleared by a write of 1; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= src | (pend_q & ~(pend_wr & pend_d));
    end
endmodule

// File: rtl/irqc_out_reg.sv
// irqc_out_reg: reduces the enabled pending bits to one registered level request.
// Assumes en and pend are aligned bit for bit.
module irqc_out_reg #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] en,
    input  logic [N-1:0] pend,
    output logic         irq_q
);
    // Output flop: high while any enabled source is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(en & pend);
    end
endmodule

// File: rtl/irq_combiner.sv
// irq_combiner: combines NUM_SRC sticky interrupt sources into one level request.
// Enables sit at bits SRC_BASE.. of the low half. Pending bits sit 16 positions
// higher and clear when written with 1.
// Assumes SRC_BASE + NUM_SRC <= 16. Reads return the live register contents.
module irq_combiner #(
    parameter int unsigned NUM_SRC  = 7,
    parameter int unsigned SRC_BASE = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [3:0]         reg_be,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq_out
);
    import irqc_pkg::*;

    localparam int unsigned TOP_BIT = SRC_BASE + NUM_SRC;

    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] pend_vec;

    initial begin
        if (TOP_BIT > HALF_W) $error("irq_combiner: sources overflow the enable half");
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int unsigned EN_POS = SRC_BASE + i;
        localparam int unsigned PD_POS = EN_POS + HALF_W;
        localparam int unsigned EN_LN  = EN_POS / LANE_W;
        localparam int unsigned PD_LN  = PD_POS / LANE_W;

        irqc_src_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_wr   (reg_wr & reg_be[EN_LN]),
            .en_d    (reg_wdata[EN_POS]),
            .pend_wr (reg_wr & reg_be[PD_LN]),
            .pend_d  (reg_wdata[PD_POS]),
            .src     (src_in[i]),
            .en_q    (en_vec[i]),
            .pend_q  (pend_vec[i])
        );
    end

    // Read mux: place both fields at their configured positions, zeros elsewhere.
    always_comb begin
        reg_rdata = '0;
        reg_rdata[SRC_BASE +: NUM_SRC]          = en_vec;
        reg_rdata[SRC_BASE + HALF_W +: NUM_SRC] = pend_vec;
    end

    irqc_out_reg #(.N(NUM_SRC)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_vec),
        .pend  (pend_vec),
        .irq_q (irq_out)
    );
endmodule

// File: rtl/irq_combiner_chk.sv
// irq_combiner_chk: port-level properties of irq_combiner, bound to every instance.
module irq_combiner_chk #(
    parameter int unsigned NUM_SRC  = 7,
    parameter int unsigned SRC_BASE = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [3:0]         reg_be,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        reg_rdata,
    input logic [NUM_SRC-1:0] src_in,
    input logic               irq_out
);
    localparam logic [31:0] USED =
        ((32'(1) << NUM_SRC) - 32'(1)) << SRC_BASE |
        ((32'(1) << NUM_SRC) - 32'(1)) << (SRC_BASE + 16);

    logic [NUM_SRC-1:0] en_rd, pd_rd;
    assign en_rd = reg_rdata[SRC_BASE +: NUM_SRC];
    assign pd_rd = reg_rdata[SRC_BASE + 16 +: NUM_SRC];

    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~USED) == 32'h0);

    a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        |(en_rd & pd_rd) |=> irq_out);

    a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(en_rd & pd_rd)) |=> !irq_out);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        localparam int unsigned EP = SRC_BASE + i;
        localparam int unsigned PP = EP + 16;

        a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_be[EP/8]) |=> reg_rdata[EP] == $past(reg_wdata[EP]));

        a_r10_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_wr && reg_be[EP/8]) |=> $stable(reg_rdata[EP]));

        a_r3_src_sets: assert property (@(posedge clk) disable iff (!rst_n)
            src_in[i] |=> reg_rdata[PP]);

        a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_be[PP/8] && reg_wdata[PP] && !src_in[i]) |=> !reg_rdata[PP]);

        a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rdata[PP] && !(reg_wr && reg_be[PP/8] && reg_wdata[PP])) |=> reg_rdata[PP]);
    end
endmodule

bind irq_combiner irq_combiner_chk #(.NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_in    (src_in),
    .irq_out   (irq_out)
);

// File: tb/tb_irq_combiner.sv
`timescale 1ns/1ps
// tb_irq_combiner: directed scenarios, one task each. Inputs change and outputs
// are sampled on the falling clock edge.
module tb_irq_combiner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] rdata, rdata2;
    logic [6:0]  src = 7'h0;
    logic [1:0]  src2 = 2'h0;
    logic        irq, irq2;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    irq_combiner #(.NUM_SRC(7), .SRC_BASE(0)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .src_in(src), .irq_out(irq));

    irq_combiner #(.NUM_SRC(2), .SRC_BASE(4)) dut_hi (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(rdata2), .src_in(src2), .irq_out(irq2));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        reg_wr = 1'b1; reg_be = be; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_be = 4'h0; reg_wdata = 32'h0;
    endtask

    task automatic pulse(input logic [6:0] s);
        src = s; tick(); src = 7'h0;
    endtask

    task automatic t_reset();
        check("R9 reg after reset", rdata, 32'h0);
        check("R9 irq after reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_enable_rw();
        wr(4'hF, 32'h0000_FFFF);
        check("R2/R8 enables written, unused zero", rdata, 32'h0000_007F);
        wr(4'b1110, 32'h0);
        check("R10 lane 0 strobe low keeps enables", rdata, 32'h0000_007F);
        wr(4'b0001, 32'h0000_0000);
        check("R2 enables cleared", rdata, 32'h0);
    endtask

    task automatic t_latch_masked();
        pulse(7'b000_0100);
        check("R3 pending set while masked", rdata, 32'h0004_0000);
        tick(); tick();
        check("R7 masked pending gives no irq", {31'h0, irq}, 32'h0);
        wr(4'b0011, 32'h0000_0004);
        check("R4 enable write with zero pending keeps pending", rdata, 32'h0004_0004);
        check("R6 irq not yet high at write edge", {31'h0, irq}, 32'h0);
        tick();
        check("R6 irq high one clock later", {31'h0, irq}, 32'h1);
    endtask

    task automatic t_clear_one_by_one();
        wr(4'b0011, 32'h0000_007F);
        pulse(7'b010_0000);
        wr(4'b0100, 32'h0004_0000);
        check("R4 clear of src2 leaves src5", rdata, 32'h0020_007F);
        check("R6 irq still high", {31'h0, irq}, 32'h1);
        wr(4'b0100, 32'h0020_0000);
        check("R4 last pending cleared", rdata, 32'h0000_007F);
        check("R6 irq still high on clear edge", {31'h0, irq}, 32'h1);
        tick();
        check("R6 irq low one clock after clear", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_mask();
        pulse(7'b000_1000);
        tick();
        check("R6 irq on enabled src3", {31'h0, irq}, 32'h1);
        wr(4'b0011, 32'h0000_0000);
        tick();
        check("R7 masking drops irq", {31'h0, irq}, 32'h0);
        check("R7 pending kept while masked", rdata, 32'h0008_0000);
        wr(4'b0100, 32'h0008_0000);
        check("R4 src3 cleared", rdata, 32'h0);
    endtask

    task automatic t_set_wins();
        src = 7'b000_0001;
        wr(4'b0100, 32'h0001_0000);
        src = 7'h0;
        check("R5 set beats clear", rdata, 32'h0001_0000);
        wr(4'b0100, 32'h0001_0000);
        check("R4 clear without source", rdata, 32'h0);
    endtask

    task automatic t_strobe_pending();
        pulse(7'b001_0000);
        wr(4'b1011, 32'h0010_0000);
        check("R10 lane 2 strobe low keeps pending", rdata, 32'h0010_0000);
        wr(4'b0100, 32'h0010_0000);
        check("R4 lane 2 strobe clears pending", rdata, 32'h0);
    endtask

    task automatic t_base_offset();
        wr(4'hF, 32'hFFFF_FFFF);
        check("R1/R8 base 4 enables", rdata2, 32'h0000_0030);
        src2 = 2'b10; tick(); src2 = 2'b00;
        check("R1 base 4 pending at bit 21", rdata2, 32'h0020_0030);
        tick();
        check("R6 base 4 irq", {31'h0, irq2}, 32'h1);
        wr(4'hF, 32'h0000_0000);
        wr(4'h4, 32'h0020_0000);
        check("R4 base 4 cleared", rdata2, 32'h0);
    endtask

    initial begin
        #(5.0 * 20000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_enable_rw();
        t_latch_masked();
        t_clear_one_by_one();
        t_mask();
        t_set_wins();
        t_strobe_pending();
        t_base_offset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule